// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block models the command front end of a byte-wide parallel NOR flash whose address space is split into uniform sectors chosen by the top address bits. A host issues bus write cycles that carry an address and a data byte. The interpreter looks for unlock-prefixed sequences and turns them into byte program, sector erase, chip erase, erase suspend and erase resume operations. While an embedded operation runs, the read path returns a status byte instead of array contents. Software polls this byte to learn whether the operation is still running and whether it has failed.

A small register array stands in for the storage cells, so the default build is small. Each sector keeps only a few bytes, addressed by the low address bits. Program time, erase time, the sector-collection window, the failure time limit and the gap allowed between command cycles are all cycle-count parameters. A bench can therefore run every operation in a few dozen clocks. Every command address is compared on the 16 bits below the sector field, so a command is recognised in any sector.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset, every byte of the array reads FFh and `busy` is 0.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, followed by one write of data D to address A, start a program. After PROG_CYCLES clocks the byte at A holds (old AND D) and `busy` returns to 0.
- R3: While an operation is busy, every address returns a status byte. In that byte, bit 7 is the complement of bit 7 of the byte being programmed (0 during an erase), and bit 6 flips on each read strobe.
- R4: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@SA open a collection window of EWIN_CYCLES clocks in which status bit 3 is 0. Each further 30h write, to any sector, adds that sector and restarts the window. Bit 3 then reads 1 while the erase runs. At the end the selected sectors read FFh and the other sectors are unchanged.
- R5: The same prefix ending in 10h@555h erases every sector.
- R6: During an erase, a window or a suspend, status bit 2 flips on reads from a selected sector and stays 0 on reads from any other sector.
- R7: If more than GAP_CYCLES clocks pass between two cycles of a sequence, the sequence is abandoned and its later cycles are not acted on.
- R8: F0h at any address, or a cycle with an unexpected data value or address, drops a partial sequence back to read mode.
- R9: A write of B0h during a running erase suspends it and `busy` goes to 0. While suspended, reads from unselected sectors return array data. Reads from selected sectors return status with bit 7 = 1, bit 6 steady and bit 2 flipping.
- R10: While suspended, a program sequence aimed at an unselected sector is carried out. One aimed at a selected sector is ignored and `busy` stays 0.
- R11: A write of 30h while suspended resumes the erase. While the erase runs, every write other than B0h is ignored.
- R12: A program that would turn a 0 bit into 1 stays busy for FAIL_CYCLES clocks and then shows status bit 5 = 1. It stays in that state until F0h is written, after which reads return the stored byte (old AND D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read strobe; advances the status toggle bits |
| addr | input | 19 | Byte address; top bits pick the sector |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Array byte or status byte |
| busy | output | 1 | High while an embedded operation or failure state holds the bus |

## Verification
The in-line assertions check several rules on every cycle:
- bit 6 flips between consecutive busy reads;
- bit 3 reads 0 in the collection window and 1 during the erase;
- a long idle gap always returns the sequence decoder to idle;
- a running erase ignores every write but suspend;
- a resume write restarts it;
- the failure state holds until reset data arrives.

Only the bench scenarios can show the storage results. These are the AND rule on programming, which sectors come back as FFh, bytes preserved in other sectors, program-during-suspend, and sequences that are rejected because of a gap, a reset byte or a wrong unlock address.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    localparam int ADDR_W = 19;
    localparam int CMD_AW = 16;

    typedef logic [7:0] byte_t;

    localparam byte_t K_UNLK1 = 8'hAA;
    localparam byte_t K_UNLK2 = 8'h55;
    localparam byte_t K_PROG  = 8'hA0;
    localparam byte_t K_ERASE = 8'h80;
    localparam byte_t K_SECT  = 8'h30;
    localparam byte_t K_CHIP  = 8'h10;
    localparam byte_t K_SUSP  = 8'hB0;
    localparam byte_t K_RESET = 8'hF0;

    localparam logic [CMD_AW-1:0] A_UNLK1 = 16'h0555;
    localparam logic [CMD_AW-1:0] A_UNLK2 = 16'h02AA;

    typedef enum logic [2:0] {
        C_IDLE, C_U1, C_U2, C_PDATA, C_E0, C_E1, C_E2
    } cseq_e;

    typedef enum logic [2:0] {
        OP_IDLE, OP_PROG, OP_EWIN, OP_ERASE, OP_SUSP, OP_SPROG, OP_FAIL
    } op_e;

    typedef struct packed {
        logic  prog;
        logic  serase;
        logic  cerase;
        byte_t data;
    } cmd_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/flash_seq_decoder.sv
module flash_seq_decoder
    import flash_cmd_pkg::*;
#(
    parameter int GAP_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] addr_lo,
    input  byte_t             wdata,
    output cmd_t              cmd
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

    cseq_e         cstate, nstate;
    logic [GW-1:0] gap;
    logic          fire;
    logic          at_u1, at_u2;

    assign fire  = wr_en && enable;
    assign at_u1 = (addr_lo == A_UNLK1);
    assign at_u2 = (addr_lo == A_UNLK2);

    always_comb begin
        nstate     = C_IDLE;
        cmd        = '0;
        cmd.data   = wdata;
        case (cstate)
            C_IDLE:  if (wdata == K_UNLK1 && at_u1) nstate = C_U1;
            C_U1:    if (wdata == K_UNLK2 && at_u2) nstate = C_U2;
            C_U2: begin
                if (at_u1 && wdata == K_PROG)       nstate = C_PDATA;
                else if (at_u1 && wdata == K_ERASE) nstate = C_E0;
            end
            C_PDATA: cmd.prog = fire;
            C_E0:    if (wdata == K_UNLK1 && at_u1) nstate = C_E1;
            C_E1:    if (wdata == K_UNLK2 && at_u2) nstate = C_E2;
            C_E2: begin
                if (wdata == K_SECT)                cmd.serase = fire;
                else if (wdata == K_CHIP && at_u1)  cmd.cerase = fire;
            end
            default: nstate = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cstate <= C_IDLE;
            gap    <= '0;
        end else if (wr_en) begin
            cstate <= nstate;
            gap    <= '0;
        end else if (cstate != C_IDLE) begin
            if (gap == GAP_LAST) begin
                cstate <= C_IDLE;
                gap    <= '0;
            end else begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R7: an idle gap reaching the limit abandons the sequence
    p_gap_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (enable && !wr_en && cstate != C_IDLE && gap == GAP_LAST) |=> (cstate == C_IDLE));
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
    import flash_cmd_pkg::*;
#(
    parameter int SECTORS = 8,
    parameter int WORDS   = 16,
    parameter int IDX_W   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_a_idx,
    input  logic [IDX_W-1:0]   rd_b_idx,
    input  logic               prog_we,
    input  logic [IDX_W-1:0]   prog_idx,
    input  byte_t              prog_data,
    input  logic               erase_we,
    input  logic [SECTORS-1:0] erase_mask,
    output byte_t              rd_a,
    output byte_t              rd_b
);
    localparam int DEPTH = SECTORS * WORDS;

    byte_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[IDX_W'(i)] <= 8'hFF;
        end else if (erase_we) begin
            for (int s = 0; s < SECTORS; s++) begin
                if (erase_mask[s]) begin
                    for (int w = 0; w < WORDS; w++) mem[IDX_W'(s * WORDS + w)] <= 8'hFF;
                end
            end
        end else if (prog_we) begin
            mem[prog_idx] <= mem[prog_idx] & prog_data;
        end
    end

    assign rd_a = mem[rd_a_idx];
    assign rd_b = mem[rd_b_idx];
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int SECTORS      = 8,
    parameter int IDX_W        = 7,
    parameter int PROG_CYCLES  = 8,
    parameter int FAIL_CYCLES  = 24,
    parameter int EWIN_CYCLES  = 12,
    parameter int ERASE_CYCLES = 60
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  byte_t                      wdata,
    input  logic [$clog2(SECTORS)-1:0] bus_sec,
    input  logic [IDX_W-1:0]           bus_idx,
    input  cmd_t                       cmd,
    input  byte_t                      tgt_old,
    output op_e                        state,
    output logic [SECTORS-1:0]         mask,
    output logic [IDX_W-1:0]           tgt_idx,
    output byte_t                      tgt_data,
    output logic                       prog_we,
    output logic                       erase_we,
    output logic                       seq_en,
    output logic                       busy
);
    localparam int MAXC  = max3(PROG_CYCLES, FAIL_CYCLES, EWIN_CYCLES);
    localparam int CW    = $clog2(MAXC + 1);
    localparam int EW    = $clog2(ERASE_CYCLES + 1);
    localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] FAIL_LAST  = CW'(FAIL_CYCLES - 1);
    localparam logic [CW-1:0] EWIN_LAST  = CW'(EWIN_CYCLES - 1);
    localparam logic [EW-1:0] ERASE_LAST = EW'(ERASE_CYCLES - 1);

    logic [CW-1:0]      cnt;
    logic [EW-1:0]      ecnt;
    logic [SECTORS-1:0] sec_oh;
    logic               bad, susp_req, resume_req, programming;

    assign sec_oh      = SECTORS'(1) << bus_sec;
    assign bad         = (tgt_old & tgt_data) != tgt_data;
    assign susp_req    = wr_en && wdata == K_SUSP;
    assign resume_req  = wr_en && wdata == K_SECT;
    assign programming = (state == OP_PROG) || (state == OP_SPROG);
    assign prog_we     = programming && (cnt == (bad ? FAIL_LAST : PROG_LAST));
    assign erase_we    = (state == OP_ERASE) && !susp_req && (ecnt == ERASE_LAST);
    assign seq_en      = (state == OP_IDLE) || (state == OP_SUSP);
    assign busy        = !seq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= OP_IDLE;
            cnt      <= '0;
            ecnt     <= '0;
            mask     <= '0;
            tgt_idx  <= '0;
            tgt_data <= 8'hFF;
        end else begin
            case (state)
                OP_IDLE: begin
                    if (cmd.prog) begin
                        state    <= OP_PROG;
                        cnt      <= '0;
                        tgt_idx  <= bus_idx;
                        tgt_data <= cmd.data;
                    end else if (cmd.serase) begin
                        state <= OP_EWIN;
                        cnt   <= '0;
                        mask  <= sec_oh;
                    end else if (cmd.cerase) begin
                        state <= OP_ERASE;
                        ecnt  <= '0;
                        mask  <= '1;
                    end
                end
                OP_PROG, OP_SPROG: begin
                    if (prog_we) begin
                        cnt <= '0;
                        if (bad)                   state <= OP_FAIL;
                        else if (state == OP_PROG) state <= OP_IDLE;
                        else                       state <= OP_SUSP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                OP_EWIN: begin
                    if (resume_req) begin
                        mask <= mask | sec_oh;
                        cnt  <= '0;
                    end else if (cnt == EWIN_LAST) begin
                        state <= OP_ERASE;
                        ecnt  <= '0;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                OP_ERASE: begin
                    if (susp_req) begin
                        state <= OP_SUSP;
                    end else if (erase_we) begin
                        state <= OP_IDLE;
                        mask  <= '0;
                    end else begin
                        ecnt <= ecnt + 1'b1;
                    end
                end
                OP_SUSP: begin
                    if (cmd.prog) begin
                        if ((mask & sec_oh) == '0) begin
                            state    <= OP_SPROG;
                            cnt      <= '0;
                            tgt_idx  <= bus_idx;
                            tgt_data <= cmd.data;
                        end
                    end else if (resume_req) begin
                        state <= OP_ERASE;
                    end
                end
                OP_FAIL: begin
                    if (wr_en && wdata == K_RESET) begin
                        state <= OP_IDLE;
                        mask  <= '0;
                    end
                end
                default: state <= OP_IDLE;
            endcase
        end
    end

    // R12: failure state persists until the reset byte arrives
    p_fail_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (state == OP_FAIL && !(wr_en && wdata == K_RESET)) |=> (state == OP_FAIL));

    // R11: a running erase ignores every write except suspend
    p_erase_ignores_r11: assert property (@(posedge clk) disable iff (rst)
        (state == OP_ERASE && !susp_req && ecnt != ERASE_LAST)
            |=> (state == OP_ERASE && mask == $past(mask)));

    // R11: resume byte during suspend restarts the erase
    p_resume_r11: assert property (@(posedge clk) disable iff (rst)
        (state == OP_SUSP && resume_req && !cmd.prog) |=> (state == OP_ERASE));
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
    import flash_cmd_pkg::*;
#(
    parameter int SECTORS       = 8,
    parameter int WORDS_PER_SEC = 16,
    parameter int PROG_CYCLES   = 8,
    parameter int FAIL_CYCLES   = 24,
    parameter int EWIN_CYCLES   = 12,
    parameter int ERASE_CYCLES  = 60,
    parameter int GAP_CYCLES    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    localparam int SW    = $clog2(SECTORS);
    localparam int OFS_W = $clog2(WORDS_PER_SEC);
    localparam int IDX_W = SW + OFS_W;

    logic [SW-1:0]      bus_sec;
    logic [IDX_W-1:0]   bus_idx, tgt_idx;
    cmd_t               cmd;
    op_e                op_state;
    logic [SECTORS-1:0] mask;
    byte_t              tgt_data, rd_a, rd_b, stat;
    logic               prog_we, erase_we, seq_en;
    logic               erasing, hit, status_sel, t6, t2;

    assign bus_sec = addr[ADDR_W-1 -: SW];
    assign bus_idx = {bus_sec, addr[OFS_W-1:0]};

    flash_seq_decoder #(.GAP_CYCLES(GAP_CYCLES)) u_dec (
        .clk(clk), .rst(rst), .enable(seq_en), .wr_en(wr_en),
        .addr_lo(addr[CMD_AW-1:0]), .wdata(wdata), .cmd(cmd)
    );

    flash_op_engine #(
        .SECTORS(SECTORS), .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES),
        .FAIL_CYCLES(FAIL_CYCLES), .EWIN_CYCLES(EWIN_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_eng (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wdata(wdata), .bus_sec(bus_sec),
        .bus_idx(bus_idx), .cmd(cmd), .tgt_old(rd_b), .state(op_state), .mask(mask),
        .tgt_idx(tgt_idx), .tgt_data(tgt_data), .prog_we(prog_we), .erase_we(erase_we),
        .seq_en(seq_en), .busy(busy)
    );

    flash_cell_array #(.SECTORS(SECTORS), .WORDS(WORDS_PER_SEC), .IDX_W(IDX_W)) u_arr (
        .clk(clk), .rst(rst), .rd_a_idx(bus_idx), .rd_b_idx(tgt_idx),
        .prog_we(prog_we), .prog_idx(tgt_idx), .prog_data(tgt_data),
        .erase_we(erase_we), .erase_mask(mask), .rd_a(rd_a), .rd_b(rd_b)
    );

    assign erasing    = (op_state == OP_EWIN) || (op_state == OP_ERASE) ||
                        (op_state == OP_SUSP) || (op_state == OP_SPROG);
    assign hit        = mask[bus_sec];
    assign status_sel = busy || (op_state == OP_SUSP && hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            t6 <= 1'b0;
            t2 <= 1'b0;
        end else if (rd_en) begin
            if (busy)           t6 <= ~t6;
            if (erasing && hit) t2 <= ~t2;
        end
    end

    always_comb begin
        stat    = '0;
        stat[6] = t6;
        stat[5] = (op_state == OP_FAIL);
        stat[3] = (op_state == OP_ERASE);
        stat[2] = erasing && hit && t2;
        case (op_state)
            OP_PROG, OP_SPROG, OP_FAIL: stat[7] = ~tgt_data[7];
            OP_SUSP:                    stat[7] = 1'b1;
            default:                    stat[7] = 1'b0;
        endcase
    end

    assign rdata = status_sel ? stat : rd_a;

    // R3: bit 6 changes between back-to-back busy reads
    p_dq6_flip_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rd_en) && $past(busy) && rd_en && busy)
            |-> (rdata[6] != $past(rdata[6])));

    // R4: bit 3 is 0 in the collection window and 1 while erasing
    p_dq3_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (op_state == OP_EWIN) |-> (rdata[3] == 1'b0));
    p_dq3_erase_r4: assert property (@(posedge clk) disable iff (rst)
        (op_state == OP_ERASE) |-> (rdata[3] == 1'b1));
endmodule

// File: tb/tb_flash_cmd_top.sv
module tb_flash_cmd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [18:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    flash_cmd_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    // {address, program data, expected byte afterwards}
    localparam logic [34:0] VEC [6] = '{
        {19'h00001, 8'hA5, 8'hA5},
        {19'h30002, 8'h3C, 8'h3C},
        {19'h7000F, 8'h7E, 8'h7E},
        {19'h00001, 8'h21, 8'h21},
        {19'h5FFF3, 8'h00, 8'h00},
        {19'h30002, 8'h0C, 8'h0C}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [18:0] a, output logic [7:0] r);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 r = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic prog(input logic [18:0] a, input logic [7:0] d);
        wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'hA0); wr(a, d);
    endtask

    task automatic erase_pre();
        wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h80);
        wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55);
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (n >= 500) chk(tag, 8'(busy), 8'h00);
    endtask

    task automatic wait_dq3(input logic [18:0] a);
        logic [7:0] r;
        for (int k = 0; k < 40; k++) begin
            rd(a, r);
            if (r[3]) break;
        end
        chk("R4 bit3 erasing", {7'b0, r[3]}, 8'h01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r, r1, r2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        chk("R1 busy", {7'b0, busy}, 8'h00);
        rd(19'h00000, r); chk("R1 byte", r, 8'hFF);
        rd(19'h7FFFF, r); chk("R1 byte", r, 8'hFF);

        // R2/R3 table-driven programs
        for (int i = 0; i < 6; i++) begin
            prog(VEC[i][34:16], VEC[i][15:8]);
            rd(VEC[i][34:16], r1); rd(VEC[i][34:16], r2);
            chk("R3 bit7", {7'b0, r1[7]}, {7'b0, ~VEC[i][15]});
            chk("R3 bit6", {7'b0, r2[6]}, {7'b0, ~r1[6]});
            wait_idle("R2 idle");
            rd(VEC[i][34:16], r); chk("R2 stored", r, VEC[i][7:0]);
        end
        rd(19'h00001, r1); rd(19'h00001, r2);
        chk("R3 no toggle idle", r2, r1);

        // R12 program that needs a 0 to become 1
        prog(19'h00001, 8'hFF);
        repeat (40) @(posedge clk);
        rd(19'h00001, r);
        chk("R12 bit5", r & 8'hA0, 8'h20);
        chk("R12 busy", {7'b0, busy}, 8'h01);
        wr(19'h12345, 8'hF0);
        rd(19'h00001, r); chk("R12 after reset", r, 8'h21);

        // R4/R6/R11 sector erase with a second sector added
        erase_pre(); wr(19'h30000, 8'h30); wr(19'h50000, 8'h30);
        rd(19'h30002, r); chk("R4 bit3 window", {7'b0, r[3]}, 8'h00);
        rd(19'h30002, r1); rd(19'h30002, r2);
        chk("R6 selected", {7'b0, r2[2]}, {7'b0, ~r1[2]});
        rd(19'h20000, r1); rd(19'h20000, r2);
        chk("R6 other", {6'b0, r1[2], r2[2]}, 8'h00);
        wait_dq3(19'h30002);
        prog(19'h7000E, 8'h00);
        chk("R11 still erasing", {7'b0, busy}, 8'h01);
        wait_idle("R4 idle");
        rd(19'h30002, r); chk("R4 erased", r, 8'hFF);
        rd(19'h5FFF3, r); chk("R4 erased", r, 8'hFF);
        rd(19'h7000F, r); chk("R4 kept", r, 8'h7E);
        rd(19'h00001, r); chk("R4 kept", r, 8'h21);
        rd(19'h7000E, r); chk("R11 ignored", r, 8'hFF);

        // R9/R10/R11 suspend and resume
        prog(19'h10004, 8'h5A); wait_idle("R2 idle");
        erase_pre(); wr(19'h10000, 8'h30);
        wait_dq3(19'h10004);
        wr(19'h00000, 8'hB0);
        chk("R9 busy", {7'b0, busy}, 8'h00);
        rd(19'h00001, r); chk("R9 data", r, 8'h21);
        rd(19'h10004, r1); rd(19'h10004, r2);
        chk("R9 bit7", {7'b0, r1[7]}, 8'h01);
        chk("R9 bit6 steady", {7'b0, r2[6]}, {7'b0, r1[6]});
        chk("R9 bit2", {7'b0, r2[2]}, {7'b0, ~r1[2]});
        prog(19'h00002, 8'h66);
        chk("R10 busy", {7'b0, busy}, 8'h01);
        wait_idle("R10 idle");
        rd(19'h00002, r); chk("R10 stored", r, 8'h66);
        prog(19'h10005, 8'h00);
        chk("R10 ignored", {7'b0, busy}, 8'h00);
        wr(19'h00000, 8'h30);
        chk("R11 resumed", {7'b0, busy}, 8'h01);
        wait_idle("R11 idle");
        rd(19'h10004, r); chk("R11 erased", r, 8'hFF);
        rd(19'h00002, r); chk("R11 kept", r, 8'h66);

        // R5 chip erase
        erase_pre(); wr(19'h00555, 8'h10);
        chk("R5 busy", {7'b0, busy}, 8'h01);
        wait_idle("R5 idle");
        rd(19'h00001, r); chk("R5 erased", r, 8'hFF);
        rd(19'h7000F, r); chk("R5 erased", r, 8'hFF);

        // R7 gap timeout, with a short-gap control
        wr(19'h00555, 8'hAA); repeat (8) @(posedge clk);
        wr(19'h002AA, 8'h55); repeat (8) @(posedge clk);
        wr(19'h00555, 8'hA0); repeat (8) @(posedge clk);
        wr(19'h00006, 8'h12); wait_idle("R7 idle");
        rd(19'h00006, r); chk("R7 short gap", r, 8'h12);
        wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55);
        repeat (20) @(posedge clk);
        wr(19'h00555, 8'hA0); wr(19'h00003, 8'h00);
        chk("R7 busy", {7'b0, busy}, 8'h00);
        rd(19'h00003, r); chk("R7 long gap", r, 8'hFF);

        // R8 reset byte and wrong unlock address
        wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55); wr(19'h12345, 8'hF0);
        wr(19'h00555, 8'hA0); wr(19'h00004, 8'h00);
        rd(19'h00004, r); chk("R8 reset", r, 8'hFF);
        wr(19'h00554, 8'hAA); wr(19'h002AA, 8'h55);
        wr(19'h00555, 8'hA0); wr(19'h00005, 8'h00);
        rd(19'h00005, r); chk("R8 bad addr", r, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule